// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog timer with two stages. Software loads a reload period and turns the timer on. The counter then counts down by one on each strobe of a slow timebase. When the count reaches zero for the first time, the block sets a timeout flag and raises a system-management interrupt request. It then reloads itself and keeps counting.

If software does not service the timer with a kick write before a second expiry, the block sets a second-timeout flag. Unless a no-reboot control is set, the block then holds a system reset request asserted. A 2-bit post-reset policy value is presented next to the reset request, so the reset sequencer can choose between a normal boot, a shutdown, or holding in the pre-boot state.

The block has two reset domains:
- An always-on reset (`rst_ni`) clears every register.
- A system reset (`sys_rst_ni`) stands for cold boot, cold reset, warm reset and sleep entry. It clears everything except the second-timeout flag and the policy field.

The enable bit can be frozen by a sticky lock bit. Once the lock is set, it stays set until a reset.

Top module: `wdog_two_stage`

## Requirements
- R1: While the enable bit (CTRL bit 0) is 1, each cycle with `tick_i` high and no kick write lowers the count (read at address 3) by one. With enable 0 or `tick_i` low, the count holds.
- R2: A tick at count 0 while enabled is an expiry. The count reloads from the period register (address 2). If the expiry is not a second one (R3), the timeout flag (STATUS bit 0, address 1) is set, and `smi_o` is high while that flag is set.
- R3: An expiry sets the second-timeout flag (STATUS bit 1) when two conditions hold: the timeout flag is set, and an earlier expiry has occurred with no kick written since.
- R4: Any write to address 3 (kick) loads the count from the period register. It also cancels the pending condition, so the next expiry sets only the timeout flag.
- R5: `reset_req_o` is high exactly while the second-timeout flag is 1 and the no-reboot bit (CTRL bit 2) is 0. `policy_o` always carries the policy field (CTRL bits 5:4).
- R6: The status flags are write-one-to-clear. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. When an expiry and a clear fall in the same cycle, the expiry wins.
- R7: Writing 1 to the lock bit (CTRL bit 1) sets it. After that, writes cannot change the enable bit, and writing 0 does not clear the lock. No-reboot, policy and period stay writable.
- R8: Asserting `sys_rst_ni` clears enable, lock, no-reboot, the timeout flag and the pending condition. It returns the period and the count to their reset value (all ones). It leaves the second-timeout flag and the policy field unchanged.
- R9: Asserting `rst_ni` clears every field, including the second-timeout flag and the policy field. Period and count return to all ones.
- R10: Reserved read bits are 0. The policy encoding is 00 boot normally, 01 shut down, 10 hold in pre-boot, 11 reserved. The field stores any written value as-is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Always-on asynchronous reset, active low |
| sys_rst_ni | input | 1 | System (cold/warm/sleep) asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one count per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 CTRL, 1 STATUS, 2 PERIOD, 3 KICK/COUNT |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| smi_o | output | 1 | System-management interrupt request |
| reset_req_o | output | 1 | System reset request |
| policy_o | output | 2 | Post-reset policy presented with the reset request |

## Verification
Some behaviours are checked by assertions on every cycle:
- the single-step decrement;
- the timeout flag being set on expiry;
- the second-timeout flag only rising out of an already-set timeout;
- that flag only falling on a write-one-to-clear;
- the lock staying set and freezing the enable bit.

Other behaviours need the bench's scenarios. These are the kick cancelling escalation, the reset request gated by no-reboot, and the split between the two reset domains. The bench covers them with directed sequences and with a long random run compared against a register-level reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_PERIOD = 2'd2,
    REG_KICK   = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_LOCK    = 1;
  localparam int CTRL_NOBOOT  = 2;
  localparam int CTRL_POL_LSB = 4;
  localparam int STAT_TO      = 0;
  localparam int STAT_SEC     = 1;

  typedef enum logic [1:0] {
    POL_BOOT     = 2'b00,
    POL_SHUTDOWN = 2'b01,
    POL_HOLD     = 2'b10,
    POL_RSVD     = 2'b11
  } policy_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] CNT_RST = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = en_i & tick_i & at_zero & ~kick_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= CNT_RST;
    else if (kick_i || expire_o)  cnt_q <= period_i;
    else if (en_i && tick_i)      cnt_q <= cnt_q - 1'b1;
  end

  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !kick_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk_i,
  input  logic aon_rst_ni,
  input  logic core_rst_ni,
  input  logic expire_i,
  input  logic kick_i,
  input  logic clr_to_i,
  input  logic clr_sec_i,
  output logic to_o,
  output logic sec_o
);
  logic to_q, sec_q, pend_q;
  logic set_to, set_sec;

  // second expiry: timeout still flagged and no kick since the previous one
  assign set_sec = expire_i & pend_q & to_q;
  assign set_to  = expire_i & ~set_sec;

  always_ff @(posedge clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) begin
      to_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (set_to)        to_q <= 1'b1;
      else if (clr_to_i) to_q <= 1'b0;
      if (kick_i)        pend_q <= 1'b0;
      else if (expire_i) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge aon_rst_ni) begin
    if (!aon_rst_ni)      sec_q <= 1'b0;
    else if (set_sec)     sec_q <= 1'b1;
    else if (clr_sec_i)   sec_q <= 1'b0;
  end

  assign to_o  = to_q;
  assign sec_o = sec_q;

  // R2
  to_on_expire_chk: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    (expire_i && !to_q) |=> to_q);

  // R3
  sec_cause_chk: assert property (@(posedge clk_i) disable iff (!aon_rst_ni || !core_rst_ni)
    $rose(sec_q) |-> $past(to_q && pend_q && expire_i));

  // R6
  sec_w1c_chk: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    $fell(sec_q) |-> $past(clr_sec_i));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             aon_rst_ni,
  input  logic             core_rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             to_i,
  input  logic             sec_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [DW-1:0]    rdata_o,
  output logic             en_o,
  output logic             noboot_o,
  output logic [1:0]       policy_o,
  output logic [CNT_W-1:0] period_o,
  output logic             kick_o,
  output logic             clr_to_o,
  output logic             clr_sec_o
);
  localparam logic [CNT_W-1:0] PERIOD_RST = '1;

  logic             en_q, lock_q, noboot_q;
  logic [1:0]       pol_q;
  logic [CNT_W-1:0] period_q;
  logic             wr_ctrl, wr_stat, wr_period;
  logic             unused_wdata;

  assign wr_ctrl   = wr_en_i && (reg_addr_e'(addr_i) == REG_CTRL);
  assign wr_stat   = wr_en_i && (reg_addr_e'(addr_i) == REG_STAT);
  assign wr_period = wr_en_i && (reg_addr_e'(addr_i) == REG_PERIOD);
  assign kick_o    = wr_en_i && (reg_addr_e'(addr_i) == REG_KICK);
  assign clr_to_o  = wr_stat & wdata_i[STAT_TO];
  assign clr_sec_o = wr_stat & wdata_i[STAT_SEC];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge core_rst_ni) begin
    if (!core_rst_ni) begin
      en_q     <= 1'b0;
      lock_q   <= 1'b0;
      noboot_q <= 1'b0;
      period_q <= PERIOD_RST;
    end else begin
      if (wr_ctrl) begin
        if (!lock_q) en_q <= wdata_i[CTRL_EN];
        lock_q   <= lock_q | wdata_i[CTRL_LOCK];
        noboot_q <= wdata_i[CTRL_NOBOOT];
      end
      if (wr_period) period_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge aon_rst_ni) begin
    if (!aon_rst_ni)  pol_q <= POL_BOOT;
    else if (wr_ctrl) pol_q <= wdata_i[CTRL_POL_LSB +: 2];
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      REG_CTRL: begin
        rdata_o[CTRL_EN]            = en_q;
        rdata_o[CTRL_LOCK]          = lock_q;
        rdata_o[CTRL_NOBOOT]        = noboot_q;
        rdata_o[CTRL_POL_LSB +: 2]  = pol_q;
      end
      REG_STAT: begin
        rdata_o[STAT_TO]  = to_i;
        rdata_o[STAT_SEC] = sec_i;
      end
      REG_PERIOD: rdata_o[CNT_W-1:0] = period_q;
      REG_KICK:   rdata_o[CNT_W-1:0] = cnt_i;
      default:    rdata_o = '0;
    endcase
  end

  assign en_o     = en_q;
  assign noboot_o = noboot_q;
  assign policy_o = pol_q;
  assign period_o = period_q;

  // R7
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    lock_q |=> lock_q);

  // R7
  en_frozen_chk: assert property (@(posedge clk_i) disable iff (!core_rst_ni)
    (lock_q && wr_ctrl) |=> $stable(en_q));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          smi_o,
  output logic          reset_req_o,
  output logic [1:0]    policy_o
);
  logic             core_rst_n;
  logic             en, noboot, kick, clr_to, clr_sec, expire, to_flag, sec_flag;
  logic [CNT_W-1:0] period, cnt;

  // always-on reset also clears the system domain
  assign core_rst_n = rst_ni & sys_rst_ni;

  wdog_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .aon_rst_ni  (rst_ni),
    .core_rst_ni (core_rst_n),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .to_i        (to_flag),
    .sec_i       (sec_flag),
    .cnt_i       (cnt),
    .rdata_o     (rdata_o),
    .en_o        (en),
    .noboot_o    (noboot),
    .policy_o    (policy_o),
    .period_o    (period),
    .kick_o      (kick),
    .clr_to_o    (clr_to),
    .clr_sec_o   (clr_sec)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (core_rst_n),
    .tick_i   (tick_i),
    .en_i     (en),
    .kick_i   (kick),
    .period_i (period),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdog_status u_stat (
    .clk_i       (clk_i),
    .aon_rst_ni  (rst_ni),
    .core_rst_ni (core_rst_n),
    .expire_i    (expire),
    .kick_i      (kick),
    .clr_to_i    (clr_to),
    .clr_sec_i   (clr_sec),
    .to_o        (to_flag),
    .sec_o       (sec_flag)
  );

  assign smi_o       = to_flag;
  assign reset_req_o = sec_flag & ~noboot;
endmodule

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/100ps
module sim_wdog_two_stage;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0, sys_rst_n = 1'b0;
  logic          tick = 1'b0, wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          smi, rreq;
  logic [1:0]    pol;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  bit m_en, m_lock, m_nb, m_to, m_sec, m_pend;
  logic [1:0]    m_pol;
  logic [CW-1:0] m_per, m_cnt;

  always #5 clk = ~clk;

  wdog_two_stage #(.DW(DW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n), .tick_i(tick),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .smi_o(smi), .reset_req_o(rreq), .policy_o(pol)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic void model_core_rst();
    m_en = 0; m_lock = 0; m_nb = 0; m_to = 0; m_pend = 0;
    m_per = '1; m_cnt = '1;
  endfunction

  function automatic void model_aon_rst();
    model_core_rst();
    m_sec = 0; m_pol = 2'b00;
  endfunction

  function automatic void model_step(bit w, logic [1:0] a, logic [DW-1:0] d, bit t);
    bit kick, exp_, s_sec, s_to;
    kick  = w && a == 2'd3;
    exp_  = m_en && t && m_cnt == '0 && !kick;
    s_sec = exp_ && m_pend && m_to;
    s_to  = exp_ && !s_sec;
    if (kick || exp_)    m_cnt = m_per;
    else if (m_en && t)  m_cnt = m_cnt - 1'b1;
    if (kick)      m_pend = 0;
    else if (exp_) m_pend = 1;
    if (s_to)                          m_to = 1;
    else if (w && a == 2'd1 && d[0])   m_to = 0;
    if (s_sec)                         m_sec = 1;
    else if (w && a == 2'd1 && d[1])   m_sec = 0;
    if (w && a == 2'd0) begin
      if (!m_lock) m_en = d[0];
      m_lock = m_lock | d[1];
      m_nb   = d[2];
      m_pol  = d[5:4];
    end
    if (w && a == 2'd2) m_per = d[CW-1:0];
  endfunction

  function automatic logic [DW-1:0] exp_read(int a);
    logic [DW-1:0] r = '0;
    case (a)
      0: begin r[0] = m_en; r[1] = m_lock; r[2] = m_nb; r[5:4] = m_pol; end
      1: begin r[0] = m_to; r[1] = m_sec; end
      2: r[CW-1:0] = m_per;
      default: r[CW-1:0] = m_cnt;
    endcase
    return r;
  endfunction

  task automatic check_all();
    for (int i = 0; i < 4; i++) begin
      addr = 2'(i);
      #0.5;
      case (i)
        0: chk("R7 ctrl", rdata, exp_read(i));
        1: chk("R3 status", rdata, exp_read(i));
        2: chk("R10 period", rdata, exp_read(i));
        default: chk("R1 count", rdata, exp_read(i));
      endcase
    end
    chk("R2 smi", DW'(smi), DW'(m_to));
    chk("R5 reset_req", DW'(rreq), DW'(m_sec && !m_nb));
    chk("R5 policy", DW'(pol), DW'(m_pol));
  endtask

  task automatic step(input bit w, input logic [1:0] a, input logic [DW-1:0] d, input bit t);
    @(negedge clk);
    wr = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    model_step(w, a, d, t);
    #0.5;
    wr = 0; tick = 0;
    check_all();
  endtask

  task automatic pulse_sys_rst();
    @(negedge clk); sys_rst_n = 0;
    @(negedge clk); sys_rst_n = 1;
    model_core_rst();
    #0.5; check_all();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_aon_rst();
    #22; rst_n = 1; sys_rst_n = 1;
    #0.5;
    // R9 reset state
    check_all();

    // R1 R2: period 2, kick, enable
    step(1, 2'd2, 16'd2, 0);
    step(1, 2'd3, 16'd0, 0);
    step(1, 2'd0, 16'h0001, 0);
    for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 1);
    chk("R2 first expiry smi", DW'(smi), 16'd1);
    // R6 write 0 to status: no effect
    step(1, 2'd1, 16'h0000, 0);
    chk("R6 w0 keeps timeout", DW'(smi), 16'd1);
    // R4 kick cancels escalation
    step(1, 2'd3, 16'h00ff, 0);
    for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 1);
    chk("R4 no second after kick", DW'(rreq), 16'd0);
    // R3 second expiry without kick
    for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 1);
    chk("R3 second expiry", DW'(rreq), 16'd1);
    // R6 clear timeout by writing 1
    step(1, 2'd1, 16'h0001, 0);
    chk("R6 w1c timeout", DW'(smi), 16'd0);
    // R7 lock with policy hold, then try to disable
    step(1, 2'd0, 16'h0023, 0);
    step(1, 2'd0, 16'h0020, 0);
    addr = 2'd0; #0.5;
    chk("R7 lock holds enable", rdata & 16'h0003, 16'h0003);
    // R5 no-reboot masks request
    step(1, 2'd0, 16'h0024, 0);
    chk("R5 noboot masks", DW'(rreq), 16'd0);
    step(1, 2'd0, 16'h0020, 0);
    // R8 system reset keeps second flag and policy
    pulse_sys_rst();
    addr = 2'd1; #0.5;
    chk("R8 second survives", rdata, 16'h0002);
    chk("R8 policy survives", DW'(pol), 16'd2);
    chk("R8 request still high", DW'(rreq), 16'd1);
    // R6 clear second
    step(1, 2'd1, 16'h0002, 0);
    chk("R6 w1c second", DW'(rreq), 16'd0);
    // R10 reserved bits
    step(1, 2'd0, 16'hfff8 | 16'h0031, 0);
    addr = 2'd0; #0.5;
    chk("R10 reserved zero", rdata & 16'hffc8, 16'h0000);

    // random run
    for (int k = 0; k < 4000; k++) begin
      int op = int'($urandom % 24);
      logic [DW-1:0] d = DW'($urandom);
      bit t = bit'($urandom % 2);
      if (op == 0 && ($urandom % 8) == 0) pulse_sys_rst();
      else if (op < 3) begin
        if (($urandom % 8) != 0) d[1] = 1'b0;
        step(1, 2'd0, d, t);
      end
      else if (op < 5)  step(1, 2'd1, d, t);
      else if (op < 6)  step(1, 2'd2, DW'($urandom % 6), t);
      else if (op < 8)  step(1, 2'd3, d, t);
      else              step(0, 2'($urandom), d, t);
    end

    // R9 full reset clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    model_aon_rst();
    #0.5; check_all();
    chk("R9 policy cleared", DW'(pol), 16'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule